// File: doc/BRIEF.md
# Supply Mode Controller

This block keeps track of the operating mode of a bus-interface supply chip. There are four visible modes: fail-safe, normal, silent and sleep. The block starts in fail-safe, where the bus transceiver is off. An enable request moves it to normal, where the transceiver is on. Two request inputs put it into silent or sleep. An ignition-style input or a bus wake indication brings it back. An active-low reset indication, driven by the watchdog or the undervoltage logic, forces fail-safe at any time.

All outputs are decoded from the registered state alone, so each one changes on the clock edge after the input that caused it. The outputs are:
- the 2-bit mode code,
- the transceiver enable,
- the inhibit switch enable,
- a flag that stops the watchdog,
- a regulator-off mark,
- an undervoltage hold flag.

Waking from sleep first runs a fixed undervoltage hold of `HOLD_CYCLES` clock cycles, because the regulator was off. Only after that hold does the block settle in fail-safe.

Top module: `supply_mode_ctrl`

## Requirements
- R1: After synchronous reset `rst`, mode_o is 00, xcvr_en_o is 0, inh_en_o is 1, wdog_off_o is 0, reg_off_o is 0 and uv_hold_o is 0.
- R2: In fail-safe with uv_hold_o low, enable_req high (with rst_event_n high) gives normal on the next cycle. xcvr_en_o is 1 only in normal.
- R3: rst_event_n low on any cycle gives fail-safe with uv_hold_o low on the next cycle, whatever the other inputs and the current mode are, including during the hold.
- R4: In normal, sleep_req gives sleep and takes priority over silent_req. Otherwise silent_req gives silent. Both requests are ignored in every other mode.
- R5: A 0-to-1 change of ign_wake between two consecutive cycles wakes the block from silent or sleep. A level held high gives no further wake. After reset the input counts as high until it has been seen low. Edges in normal or fail-safe have no effect.
- R6: bus_wake high on any cycle wakes the block from silent or sleep.
- R7: A wake from silent gives fail-safe on the next cycle. A wake from sleep raises uv_hold_o for exactly HOLD_CYCLES cycles, with mode_o reading 00, and then gives fail-safe. enable_req is ignored during the hold.
- R8: inh_en_o is 1 in fail-safe (including the hold) and in normal, and 0 in silent and sleep.
- R9: wdog_off_o is 1 in silent, in sleep and during the undervoltage hold, and 0 otherwise.
- R10: reg_off_o is 1 only in sleep.
- R11: mode_o encodes fail-safe as 00, normal as 01, silent as 10 and sleep as 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_req | input | 1 | Request to move from fail-safe to normal |
| rst_event_n | input | 1 | Low while a watchdog or undervoltage reset is active |
| silent_req | input | 1 | Request to enter silent from normal |
| sleep_req | input | 1 | Request to enter sleep from normal |
| ign_wake | input | 1 | Ignition wake input, acts on its rising edge |
| bus_wake | input | 1 | Bus wake indication, acts on its level |
| mode_o | output | 2 | Current mode code |
| xcvr_en_o | output | 1 | Bus transceiver enable |
| inh_en_o | output | 1 | Inhibit high-side switch enable |
| wdog_off_o | output | 1 | Watchdog stopped |
| reg_off_o | output | 1 | Regulator marked off |
| uv_hold_o | output | 1 | Undervoltage hold in progress after a wake from sleep |

## Verification
On every cycle, the assertions check the following:
- that the mode and the output flags agree with each other,
- that a reset indication forces fail-safe,
- the single-step transitions out of fail-safe, normal and the two low-power modes,
- that a held ignition level does not wake silent mode.

Some behaviour spans many cycles or depends on the order of events, so only the bench's scenarios can show it:
- the exact length of the hold after a wake from sleep,
- that enable is ignored during that hold,
- that the ignition edge detector has been tracking the input while the block was in another mode,
- how the block behaves under long mixed random stimulus, compared with a behavioural model.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        MODE_FAILSAFE = 2'b00,
        MODE_NORMAL   = 2'b01,
        MODE_SILENT   = 2'b10,
        MODE_SLEEP    = 2'b11
    } smc_mode_e;

    typedef enum logic [2:0] {
        ST_FAILSAFE,
        ST_NORMAL,
        ST_SILENT,
        ST_SLEEP,
        ST_UVHOLD
    } smc_state_e;

    typedef struct packed {
        smc_mode_e mode;
        logic      xcvr_en;
        logic      inh_en;
        logic      wdog_off;
        logic      reg_off;
        logic      uv_hold;
    } smc_out_t;

    function automatic smc_out_t smc_decode(smc_state_e st);
        smc_out_t o;
        o = '{mode: MODE_FAILSAFE, xcvr_en: 1'b0, inh_en: 1'b1,
              wdog_off: 1'b0, reg_off: 1'b0, uv_hold: 1'b0};
        unique case (st)
            ST_FAILSAFE: ;
            ST_NORMAL: begin
                o.mode    = MODE_NORMAL;
                o.xcvr_en = 1'b1;
            end
            ST_SILENT: begin
                o.mode     = MODE_SILENT;
                o.inh_en   = 1'b0;
                o.wdog_off = 1'b1;
            end
            ST_SLEEP: begin
                o.mode     = MODE_SLEEP;
                o.inh_en   = 1'b0;
                o.wdog_off = 1'b1;
                o.reg_off  = 1'b1;
            end
            ST_UVHOLD: begin
                o.wdog_off = 1'b1;
                o.uv_hold  = 1'b1;
            end
            default: ;
        endcase
        return o;
    endfunction

    function automatic logic smc_is_lowpower(smc_state_e st);
        return (st == ST_SILENT) || (st == ST_SLEEP);
    endfunction

endpackage

// File: rtl/smc_wake_detect.sv
module smc_wake_detect (
    input  logic clk,
    input  logic rst,
    input  logic ign_in,
    input  logic bus_in,
    output logic wake_o
);
    logic ign_q;
    logic ign_rise;

    // The previous ignition level resets high so that a level already
    // present at reset is not taken for an edge.
    always_ff @(posedge clk) begin
        if (rst) ign_q <= 1'b1;
        else     ign_q <= ign_in;
    end

    assign ign_rise = ign_in & ~ign_q;
    assign wake_o   = ign_rise | bus_in;
endmodule

// File: rtl/smc_hold_timer.sv
module smc_hold_timer #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic done_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active_i) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done_o = active_i && (cnt == LAST);
endmodule

// File: rtl/supply_mode_ctrl.sv
module supply_mode_ctrl
    import smc_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable_req,
    input  logic       rst_event_n,
    input  logic       silent_req,
    input  logic       sleep_req,
    input  logic       ign_wake,
    input  logic       bus_wake,
    output logic [1:0] mode_o,
    output logic       xcvr_en_o,
    output logic       inh_en_o,
    output logic       wdog_off_o,
    output logic       reg_off_o,
    output logic       uv_hold_o
);
    smc_state_e state_q, state_d;
    logic       wake;
    logic       hold_done;
    smc_out_t   outs;

    smc_wake_detect u_wake (
        .clk    (clk),
        .rst    (rst),
        .ign_in (ign_wake),
        .bus_in (bus_wake),
        .wake_o (wake)
    );

    smc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .active_i (state_q == ST_UVHOLD),
        .done_o   (hold_done)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_event_n) begin
            state_d = ST_FAILSAFE;
        end else begin
            unique case (state_q)
                ST_FAILSAFE: if (enable_req) state_d = ST_NORMAL;
                ST_NORMAL: begin
                    if (sleep_req)       state_d = ST_SLEEP;
                    else if (silent_req) state_d = ST_SILENT;
                end
                ST_SILENT: if (wake) state_d = ST_FAILSAFE;
                ST_SLEEP:  if (wake) state_d = ST_UVHOLD;
                ST_UVHOLD: if (hold_done) state_d = ST_FAILSAFE;
                default:   state_d = ST_FAILSAFE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FAILSAFE;
        else     state_q <= state_d;
    end

    assign outs       = smc_decode(state_q);
    assign mode_o     = outs.mode;
    assign xcvr_en_o  = outs.xcvr_en;
    assign inh_en_o   = outs.inh_en;
    assign wdog_off_o = outs.wdog_off;
    assign reg_off_o  = outs.reg_off;
    assign uv_hold_o  = outs.uv_hold;
endmodule

// File: rtl/smc_checker.sv
module smc_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable_req,
    input logic       rst_event_n,
    input logic       silent_req,
    input logic       sleep_req,
    input logic       ign_wake,
    input logic       bus_wake,
    input logic [1:0] mode_o,
    input logic       xcvr_en_o,
    input logic       inh_en_o,
    input logic       wdog_off_o,
    input logic       reg_off_o,
    input logic       uv_hold_o
);
    AST_RESET_FORCES_FAILSAFE: assert property (@(posedge clk) disable iff (rst)
        !rst_event_n |=> (mode_o == 2'b00 && !uv_hold_o)); // R3

    AST_ENABLE_TO_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00 && !uv_hold_o && enable_req && rst_event_n) |=> mode_o == 2'b01); // R2

    AST_XCVR_ONLY_NORMAL: assert property (@(posedge clk) disable iff (rst)
        xcvr_en_o |-> mode_o == 2'b01); // R2

    AST_SLEEP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01 && rst_event_n && sleep_req) |=> mode_o == 2'b11); // R4

    AST_SILENT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b01 && rst_event_n && !sleep_req && silent_req) |=> mode_o == 2'b10); // R4

    AST_IGN_LEVEL_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && rst_event_n && !bus_wake && ign_wake && $past(ign_wake))
        |=> mode_o == 2'b10); // R5

    AST_BUS_WAKE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && rst_event_n && bus_wake) |=> (mode_o == 2'b00 && !uv_hold_o)); // R6

    AST_SLEEP_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b11 && rst_event_n && bus_wake) |=> uv_hold_o); // R7

    AST_HOLD_READS_FAILSAFE: assert property (@(posedge clk) disable iff (rst)
        uv_hold_o |-> (mode_o == 2'b00 && !xcvr_en_o)); // R7

    AST_INH_BY_MODE: assert property (@(posedge clk) disable iff (rst)
        inh_en_o == !mode_o[1]); // R8

    AST_WDOG_OFF_LOWPOWER: assert property (@(posedge clk) disable iff (rst)
        wdog_off_o == (mode_o[1] || uv_hold_o)); // R9

    AST_REG_OFF_SLEEP: assert property (@(posedge clk) disable iff (rst)
        reg_off_o == (mode_o == 2'b11)); // R10
endmodule

bind supply_mode_ctrl smc_checker i_smc_checker (
    .clk         (clk),
    .rst         (rst),
    .enable_req  (enable_req),
    .rst_event_n (rst_event_n),
    .silent_req  (silent_req),
    .sleep_req   (sleep_req),
    .ign_wake    (ign_wake),
    .bus_wake    (bus_wake),
    .mode_o      (mode_o),
    .xcvr_en_o   (xcvr_en_o),
    .inh_en_o    (inh_en_o),
    .wdog_off_o  (wdog_off_o),
    .reg_off_o   (reg_off_o),
    .uv_hold_o   (uv_hold_o)
);

// File: tb/test_supply_mode_ctrl.sv
module test_supply_mode_ctrl;
    localparam int HOLD = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable_req = 0, rst_event_n = 1, silent_req = 0, sleep_req = 0;
    logic ign_wake = 0, bus_wake = 0;
    logic [1:0] mode_o;
    logic xcvr_en_o, inh_en_o, wdog_off_o, reg_off_o, uv_hold_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state: 0 fail-safe, 1 normal, 2 silent, 3 sleep, 4 hold
    int m_st = 0;
    int m_cnt = 0;
    bit m_ign_prev = 1;

    always #5 clk = ~clk;

    supply_mode_ctrl #(.HOLD_CYCLES(HOLD)) i_supply_mode_ctrl (
        .clk(clk), .rst(rst), .enable_req(enable_req), .rst_event_n(rst_event_n),
        .silent_req(silent_req), .sleep_req(sleep_req), .ign_wake(ign_wake),
        .bus_wake(bus_wake), .mode_o(mode_o), .xcvr_en_o(xcvr_en_o),
        .inh_en_o(inh_en_o), .wdog_off_o(wdog_off_o), .reg_off_o(reg_off_o),
        .uv_hold_o(uv_hold_o)
    );

    always @(posedge clk) begin
        bit wk;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_ign_prev = 1;
        end else begin
            wk = (ign_wake && !m_ign_prev) || bus_wake;
            if (!rst_event_n) m_st = 0;
            else case (m_st)
                0: if (enable_req) m_st = 1;
                1: if (sleep_req) m_st = 3; else if (silent_req) m_st = 2;
                2: if (wk) m_st = 0;
                3: if (wk) begin m_st = 4; m_cnt = 0; end
                default: if (m_cnt == HOLD - 1) m_st = 0; else m_cnt++;
            endcase
            m_ign_prev = ign_wake;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R11 mode", mode_o, (m_st == 4) ? 0 : m_st);
            chk("R2 xcvr_en", xcvr_en_o, m_st == 1);
            chk("R8 inh_en", inh_en_o, (m_st < 2) || (m_st == 4));
            chk("R9 wdog_off", wdog_off_o, m_st >= 2);
            chk("R10 reg_off", reg_off_o, m_st == 3);
            chk("R7 uv_hold", uv_hold_o, m_st == 4);
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (HOLD * 3000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        // R1 reset state (observed before the first active edge after reset)
        chk("R1 mode", mode_o, 0);
        chk("R1 xcvr", xcvr_en_o, 0);
        chk("R1 inh", inh_en_o, 1);
        chk("R1 wdog", wdog_off_o | reg_off_o | uv_hold_o, 0);
        tick(2);
        chk("R1 stays fail-safe", mode_o, 0);

        // R2 enable
        enable_req = 1; tick();
        chk("R2 normal", mode_o, 1);
        chk("R2 xcvr on", xcvr_en_o, 1);

        // R4 silent entry, then R5 ignition edge wake
        silent_req = 1; tick(); silent_req = 0; enable_req = 0;
        chk("R4 silent", mode_o, 2);
        tick(3);
        chk("R4 stays silent", mode_o, 2);
        ign_wake = 1; tick();
        chk("R5 edge wakes silent", mode_o, 0);
        chk("R7 no hold from silent", uv_hold_o, 0);

        // R5 held level does not wake
        enable_req = 1; tick(); enable_req = 0;
        silent_req = 1; tick(); silent_req = 0;
        tick(5);
        chk("R5 level no wake", mode_o, 2);
        ign_wake = 0; tick(); ign_wake = 1; tick();
        chk("R5 second edge wakes", mode_o, 0);
        ign_wake = 0;

        // R4 sleep priority, R7 hold
        enable_req = 1; tick();
        sleep_req = 1; silent_req = 1; tick(); sleep_req = 0; silent_req = 0;
        chk("R4 sleep priority", mode_o, 3);
        chk("R10 reg off", reg_off_o, 1);
        tick(3);
        chk("R2 enable ignored in sleep", mode_o, 3);
        bus_wake = 1; tick(); bus_wake = 0;
        begin
            int hc = 0;
            while (uv_hold_o && hc < HOLD + 4) begin hc++; tick(); end
            chk("R7 hold length", hc, HOLD);
        end
        chk("R7 fail-safe after hold", mode_o, 0);
        tick();
        chk("R2 normal after hold", mode_o, 1);

        // R3 reset events from normal, sleep and hold
        rst_event_n = 0; tick(); rst_event_n = 1; enable_req = 0;
        chk("R3 from normal", mode_o, 0);
        sleep_req = 1; silent_req = 1; tick();
        chk("R4 requests ignored in fail-safe", mode_o, 0);
        sleep_req = 0; silent_req = 0;
        enable_req = 1; tick(); enable_req = 0;
        ign_wake = 1; tick(); ign_wake = 0;
        chk("R5 edge ignored in normal", mode_o, 1);
        sleep_req = 1; tick(); sleep_req = 0;
        rst_event_n = 0; tick(); rst_event_n = 1;
        chk("R3 from sleep", mode_o, 0);
        enable_req = 1; tick(); sleep_req = 1; tick(); sleep_req = 0; enable_req = 0;
        ign_wake = 1; tick(); ign_wake = 0;
        chk("R5 edge wakes sleep", uv_hold_o, 1);
        tick(3);
        rst_event_n = 0; enable_req = 1; tick(); rst_event_n = 1; enable_req = 0;
        chk("R3 during hold", uv_hold_o, 0);
        chk("R3 mode during hold", mode_o, 0);
        // R6 bus wake from silent
        enable_req = 1; tick(); silent_req = 1; tick(); silent_req = 0; enable_req = 0;
        bus_wake = 1; tick(); bus_wake = 0;
        chk("R6 bus wake silent", mode_o, 0);

        // mixed random stimulus, compared against the model
        for (int i = 0; i < 3000; i++) begin
            enable_req  = ($urandom_range(0, 3) == 0);
            rst_event_n = ($urandom_range(0, 40) != 0);
            silent_req  = ($urandom_range(0, 5) == 0);
            sleep_req   = ($urandom_range(0, 7) == 0);
            ign_wake    = ($urandom_range(0, 9) < 4) ? ~ign_wake : ign_wake;
            bus_wake    = ($urandom_range(0, 30) == 0);
            tick();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule